// File: doc/BRIEF.md
# Signed-Digit Recoded Significand Multiplier

This block multiplies two unsigned 24-bit floating-point significands and returns the exact 48-bit product together with a normalized, rounded 24-bit significand. It does not walk the multiplier bit by bit. Instead it rewrites the multiplier as a string of signed digits, each −1, 0 or +1, such that no two neighbouring digits are both nonzero. It then forms one partial product for each nonzero digit. A +1 digit adds the multiplicand shifted to that digit's weight, and a −1 digit adds the shifted two's complement of the multiplicand. Zero digits are skipped and cost no cycle.

A start strobe captures both operands in the same cycle. The block then spends one cycle on each nonzero digit and one closing cycle. In that closing cycle the exact product is normalized and rounded, and all three results are loaded into output registers. A one-cycle done strobe follows. The caller supplies the exponent and the sign of the full floating-point product. The exponent-increment output tells the caller when the significand was shifted right or rounded up into the next binade.

Top module: `csdm_mult`

## Requirements
- R1: The multiplier is recoded into 25 signed digits d[0..24], each −1, 0 or +1, whose weighted sum Σ d[i]·2^i equals the multiplier value.
- R2: No two adjacent digits of the recoding are both nonzero. The number of nonzero digits k is therefore the minimum possible for the value, and k is at most 13.
- R3: When done is high, `product` equals the exact unsigned product mcand × mplier in 48 bits, for any 24-bit operand values, including zero.
- R4: `done` is high for exactly one cycle. It rises after the (k+1)-th rising clock edge following the edge at which start was accepted, where k is the nonzero digit count of R2.
- R5: If product bit 47 is 1, `expInc` is 1 and the rounded result is taken from product bits 47..24, with bit 23 as guard and bits 22..0 as sticky. Otherwise it is taken from bits 46..23, with bit 22 as guard and bits 21..0 as sticky, and `expInc` is 0 unless R6 applies.
- R6: Rounding is to nearest, with ties to even: the kept field is incremented when guard is 1 and either sticky or the kept LSB is 1. If the increment carries out of 24 bits, `rounded` becomes 0x800000 and `expInc` is 1.
- R7: A start that is high while an operation is in progress has no effect. It does not change the running result and produces no extra done.
- R8: After reset, `product`, `rounded`, `expInc` and `done` are all 0.
- R9: `product`, `rounded` and `expInc` hold their values from one done until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle; ignored while busy |
| mcand | input | 24 | Multiplicand significand |
| mplier | input | 24 | Multiplier significand, recoded into signed digits |
| product | output | 48 | Exact unsigned product |
| rounded | output | 24 | Normalized, rounded significand |
| expInc | output | 1 | Exponent must be incremented by one |
| done | output | 1 | One-cycle strobe: results updated |

## Verification
The hardest case to reach from the ports is a rounding carry that ripples all the way out of the 24-bit field. It needs a product whose bits 46..0 are all ones, with guard set and bit 47 clear. The stimulus uses the factor pair 10610063 × 13264529, whose product is exactly 2^47 − 1. Ties to even come from 0x800001 × 0xC00000, and the longest digit strings come from alternating bit patterns. Because digits are never visible at the ports, the bench predicts the nonzero digit count of each multiplier from an independent closed form and checks the done latency against it. A latency above the minimum exposes any recoding that leaves two adjacent nonzero digits.

// File: rtl/csdm_pkg.sv
`timescale 1ns/1ps
package csdm_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;    // capture operands and recoded digits, clear accumulator
    logic step;    // consume the lowest nonzero digit
    logic finish;  // register product, rounded result and flag
  } ctrlStrobes_t;

endpackage

// File: rtl/csdm_recoder.sv
`timescale 1ns/1ps
// Carry-chain recoder: unsigned value -> minimal signed-digit string.
module csdm_recoder #(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] mplier,
  output logic [SIG_W:0]   digNz,   // digit i is nonzero
  output logic [SIG_W:0]   digNeg   // digit i is -1 (only when nonzero)
);
  localparam int DIG_W = SIG_W + 1;

  logic [SIG_W+1:0] xExt;
  logic [DIG_W-1:0] carry;

  assign xExt     = {2'b00, mplier};
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < DIG_W; g++) begin : gDigit
    assign digNz[g]  = xExt[g] ^ carry[g];
    assign digNeg[g] = digNz[g] & xExt[g+1];
    if (g < DIG_W - 1) begin : gCarry
      assign carry[g+1] = digNz[g] ? xExt[g+1] : xExt[g];
    end
  end
endmodule

// File: rtl/csdm_round.sv
`timescale 1ns/1ps
// Normalize by at most one place and round to nearest, ties to even.
module csdm_round #(
  parameter int SIG_W = 24
) (
  input  logic [2*SIG_W-1:0] prod,
  output logic [SIG_W-1:0]   rounded,
  output logic               expInc
);
  localparam int PW = 2 * SIG_W;

  logic             topSet, guardBit, stickyBit, roundUp;
  logic [SIG_W-1:0] keep;
  logic [SIG_W:0]   sum;

  always_comb begin
    topSet    = prod[PW-1];
    keep      = topSet ? prod[PW-1:SIG_W]   : prod[PW-2:SIG_W-1];
    guardBit  = topSet ? prod[SIG_W-1]      : prod[SIG_W-2];
    stickyBit = topSet ? (|prod[SIG_W-2:0]) : (|prod[SIG_W-3:0]);
    roundUp   = guardBit & (stickyBit | keep[0]);
    sum       = {1'b0, keep} + (SIG_W+1)'(roundUp);
    if (sum[SIG_W]) begin
      rounded = {1'b1, {(SIG_W-1){1'b0}}};
      expInc  = 1'b1;
    end else begin
      rounded = sum[SIG_W-1:0];
      expInc  = topSet;
    end
  end
endmodule

// File: rtl/csdm_datapath.sv
`timescale 1ns/1ps
module csdm_datapath
  import csdm_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [SIG_W-1:0]     mcand,
  input  logic [SIG_W:0]       digNz,
  input  logic [SIG_W:0]       digNeg,
  output logic                 maskEmpty,
  output logic [2*SIG_W-1:0]   product,
  output logic [SIG_W-1:0]     rounded,
  output logic                 expInc
);
  localparam int DIG_W = SIG_W + 1;
  localparam int PW    = 2 * SIG_W;
  localparam int IDX_W = $clog2(DIG_W);

  logic [PW-1:0]    posM, negM, acc, partial, shifted;
  logic [DIG_W-1:0] nzMask, negMask, pick;
  logic [IDX_W-1:0] idx;
  logic             pickNeg;
  logic [SIG_W-1:0] rndOut;
  logic             rndInc;

  // Shift control: lowest remaining nonzero digit, its sign and weight.
  always_comb begin
    pick = nzMask & (~nzMask + DIG_W'(1));
    idx  = '0;
    for (int i = 0; i < DIG_W; i++) begin
      if (pick[i]) idx = IDX_W'(i);
    end
    pickNeg = |(pick & negMask);
    partial = pickNeg ? negM : posM;
    shifted = partial << idx;
  end

  assign maskEmpty = ~|nzMask;

  csdm_round #(.SIG_W(SIG_W)) u_round (
    .prod    (acc),
    .rounded (rndOut),
    .expInc  (rndInc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posM    <= '0;
      negM    <= '0;
      acc     <= '0;
      nzMask  <= '0;
      negMask <= '0;
      product <= '0;
      rounded <= '0;
      expInc  <= 1'b0;
    end else begin
      if (strobes.load) begin
        posM    <= {{SIG_W{1'b0}}, mcand};
        negM    <= ~{{SIG_W{1'b0}}, mcand} + PW'(1);
        acc     <= '0;
        nzMask  <= digNz;
        negMask <= digNeg;
      end else if (strobes.step) begin
        acc    <= acc + shifted;
        nzMask <= nzMask & ~pick;
      end
      if (strobes.finish) begin
        product <= acc;
        rounded <= rndOut;
        expInc  <= rndInc;
      end
    end
  end
endmodule

// File: rtl/csdm_ctrl.sv
`timescale 1ns/1ps
module csdm_ctrl
  import csdm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         maskEmpty,
  output ctrlStrobes_t strobes,
  output logic         done
);
  ctrlState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        strobes.load = 1'b1;
        stateNext    = ST_RUN;
      end
      ST_RUN: if (maskEmpty) begin
        strobes.finish = 1'b1;
        stateNext      = ST_IDLE;
      end else begin
        strobes.step = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.finish;
    end
  end
endmodule

// File: rtl/csdm_mult.sv
`timescale 1ns/1ps
module csdm_mult
  import csdm_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [SIG_W-1:0]     mcand,
  input  logic [SIG_W-1:0]     mplier,
  output logic [2*SIG_W-1:0]   product,
  output logic [SIG_W-1:0]     rounded,
  output logic                 expInc,
  output logic                 done
);
  ctrlStrobes_t strobes;
  logic         maskEmpty;
  logic [SIG_W:0] recNz, recNeg;

  csdm_recoder #(.SIG_W(SIG_W)) u_recoder (
    .mplier (mplier),
    .digNz  (recNz),
    .digNeg (recNeg)
  );

  csdm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .maskEmpty (maskEmpty),
    .strobes   (strobes),
    .done      (done)
  );

  csdm_datapath #(.SIG_W(SIG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .mcand     (mcand),
    .digNz     (recNz),
    .digNeg    (recNeg),
    .maskEmpty (maskEmpty),
    .product   (product),
    .rounded   (rounded),
    .expInc    (expInc)
  );
endmodule

// File: rtl/csdm_checker.sv
`timescale 1ns/1ps
module csdm_checker #(
  parameter int SIG_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [SIG_W-1:0]   mcand,
  input logic [SIG_W-1:0]   mplier,
  input logic [SIG_W:0]     digNz,
  input logic [SIG_W:0]     digNeg,
  input logic [2*SIG_W-1:0] product,
  input logic               done
);
  localparam int PW = 2 * SIG_W;

  logic             busyC;
  logic [SIG_W-1:0] capA, capB;
  int               cnt;
  logic [SIG_W+1:0] bExt, b3;
  int               nzCount;

  assign bExt    = {2'b00, capB};
  assign b3      = bExt * (SIG_W+2)'(3);
  assign nzCount = $countones((b3 ^ bExt) >> 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC <= 1'b0;
      capA  <= '0;
      capB  <= '0;
      cnt   <= 0;
    end else if (start && (!busyC || done)) begin
      busyC <= 1'b1;
      capA  <= mcand;
      capB  <= mplier;
      cnt   <= 0;
    end else if (done) begin
      busyC <= 1'b0;
    end else if (busyC) begin
      cnt <= cnt + 1;
    end
  end

  AST_CSD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, digNz & ~digNeg} - {1'b0, digNz & digNeg}) == {2'b00, mplier}); // R1

  AST_NO_ADJ_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (digNz & (digNz >> 1)) == '0); // R2

  AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product == ({{SIG_W{1'b0}}, capA} * {{SIG_W{1'b0}}, capB})); // R3

  AST_DIGIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cnt == nzCount + 1); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4

  AST_PRODUCT_FITS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product[PW-1:PW-2] != 2'b00 || capA[SIG_W-1] == 1'b0 || capB[SIG_W-1] == 1'b0); // R5
endmodule

bind csdm_mult csdm_checker #(.SIG_W(SIG_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .mcand   (mcand),
  .mplier  (mplier),
  .digNz   (recNz),
  .digNeg  (recNeg),
  .product (product),
  .done    (done)
);

// File: tb/sim_csdm_mult.sv
`timescale 1ns/1ps
module sim_csdm_mult;
  localparam int SW = 24;
  localparam int PW = 48;

  logic          clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [SW-1:0] mcand = '0, mplier = '0;
  logic [PW-1:0] product;
  logic [SW-1:0] rounded;
  logic          expInc, done;

  typedef struct {
    logic [PW-1:0] prod;
    logic [SW-1:0] rnd;
    logic          inc;
    int            lat;
    int            t0;
  } item_t;

  item_t q[$];
  item_t lastItem;
  int    cyc = 0, nChk = 0, nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  csdm_mult u0 (
    .clk(clk), .rstN(rstN), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product), .rounded(rounded), .expInc(expInc), .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  function automatic item_t model(input logic [SW-1:0] a, input logic [SW-1:0] b);
    item_t it;
    logic [63:0] p, keep, rem, half;
    logic [25:0] b1, b3;
    int sh;
    p    = 64'(a) * 64'(b);
    sh   = p[47] ? 24 : 23;
    keep = p >> sh;
    rem  = p & ((64'd1 << sh) - 1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && keep[0])) keep = keep + 1;
    it.prod = p[47:0];
    if (keep == 64'h1000000) begin
      it.rnd = 24'h800000;
      it.inc = 1'b1;
    end else begin
      it.rnd = keep[23:0];
      it.inc = p[47];
    end
    b1 = {2'b00, b};
    b3 = b1 * 26'd3;
    it.lat = $countones((b3 ^ b1) >> 1) + 2;
    it.t0  = 0;
    return it;
  endfunction

  // Monitor: pop and compare on every done.
  always @(negedge clk) begin
    if (rstN && done) begin
      if (q.size() == 0) begin
        check("R7 unexpected done", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        check("R3 R1 product", 64'(product), 64'(it.prod));
        check("R5 R6 rounded", 64'(rounded), 64'(it.rnd));
        check("R5 R6 expInc", 64'(expInc), 64'(it.inc));
        check("R2 R4 latency", 64'(cyc - it.t0), 64'(it.lat));
        lastItem = it;
      end
    end
  end

  // Watchdog.
  always @(negedge clk) begin
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL R4 watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  // Driver: push expectation, strobe start, optionally re-strobe with other operands.
  task automatic runOp(input logic [SW-1:0] a, input logic [SW-1:0] b, input bit intrude);
    item_t it;
    @(negedge clk);
    it    = model(a, b);
    it.t0 = cyc;
    q.push_back(it);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    @(negedge clk);
    if (intrude) begin
      mcand  = ~a;            // R7: start still high, different operands
      mplier = b ^ 24'h5A5A5A;
      @(negedge clk);
    end
    start  = 1'b0;
    mcand  = $urandom();
    mplier = $urandom();
    wait (q.size() == 0);
    @(negedge clk);
    // R9: results hold, no further done
    repeat (2) @(negedge clk);
    check("R9 hold product", 64'(product), 64'(lastItem.prod));
    check("R9 hold rounded", 64'(rounded), 64'(lastItem.rnd));
    check("R7 R4 done low", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset product", 64'(product), 64'd0);
    check("R8 reset rounded", 64'(rounded), 64'd0);
    check("R8 reset expInc", 64'(expInc), 64'd0);
    check("R8 reset done", 64'(done), 64'd0);
    rstN = 1'b1;

    runOp(24'd0, 24'd0, 1'b0);                 // zero digits, k = 0
    runOp(24'hFFFFFF, 24'hFFFFFF, 1'b0);       // largest product, top bit set
    runOp(24'h800000, 24'h800000, 1'b0);       // exact power of two
    runOp(24'd10610063, 24'd13264529, 1'b0);   // R6: 2^47-1, carry out of field
    runOp(24'h800001, 24'hC00000, 1'b0);       // R6: tie, round to even
    runOp(24'hABCDEF, 24'h555555, 1'b1);       // long digit string, re-strobe
    runOp(24'h123456, 24'hAAAAAB, 1'b0);
    runOp(24'd1, 24'hFFFFFF, 1'b1);            // short recoding of all ones
    runOp(24'hFFFFFF, 24'd0, 1'b1);            // k = 0 with re-strobe
    runOp(24'hC00000, 24'hB6DB6D, 1'b0);

    for (int n = 0; n < 200; n++) begin
      logic [SW-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (n % 2 == 0) begin
        ra[SW-1] = 1'b1;
        rb[SW-1] = 1'b1;
      end
      runOp(ra, rb, (n % 5) == 0);
    end

    check("R7 scoreboard empty", 64'(q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule